// File: doc/BRIEF.md
# Set/Clear General-Purpose I/O Port

This block is a general-purpose I/O port with one line per bit, 32 lines by default. A simple register bus reaches it: select, write enable, an address, write data and combinational read data. Each line has its own direction bit. An output register supplies the value for every line. The output enable of a line follows its direction bit, so the pad logic outside the block drives only the lines marked as outputs.

Firmware can change the output register in three ways. It can write a whole new value. It can write a mask whose 1 bits are forced high. It can write a mask whose 1 bits are forced low. The set and clear locations mean a single bus write changes some lines without disturbing the others, so no read-modify-write sequence is needed. Input levels pass through a chain of synchronizer flops before the bus can read them. Reading the pin location returns these synchronized levels for every line, whatever its direction.

Register indices use the low three address bits: 0 pins (read only), 1 output value, 2 set mask (write only), 3 clear mask (write only), 4 direction. Any higher address bit must be zero for the address to match.

Top module: `gpio_setclr_port`

## Requirements
- R1: Reset is active low. After reset the direction register and the output register are all zeros, so every line is an input with pin_oe all zero and pin_out all zero.
- R2: A selected write to index 1 replaces the whole output register. The new value appears on pin_out after the write's clock edge.
- R3: A selected write to index 2 sets each output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R4: A selected write to index 3 clears each output bit whose write-data bit is 1 and leaves the other output bits unchanged.
- R5: A selected write to index 4 loads the direction register, where 1 means output and 0 means input. pin_oe equals the direction register, and reading index 4 returns it.
- R6: pin_out always equals the output register, whatever the direction bits are. Changing the direction register does not alter pin_out.
- R7: Reading index 0 returns pin_in delayed by two flops. A change on pin_in is still hidden after the first rising edge and is visible after the second.
- R8: A read returns the output register at index 1 and the direction register at index 4. It returns zero at indices 2 and 3, at indices 5 to 7, and whenever bus_sel is low or bus_we is high.
- R9: Writes to index 0, to indices 5 to 7, or to any address with a nonzero bit above bit 2 change neither the output register nor the direction register.
- R10: With bus_sel low, bus_we high has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_we | input | 1 | Write enable, valid with bus_sel |
| bus_addr | input | ADDR_W (5) | Register index; bits above 2 must be zero |
| bus_wdata | input | WIDTH (32) | Write data or mask |
| bus_rdata | output | WIDTH (32) | Combinational read data |
| pin_in | input | WIDTH (32) | Input levels from the pads |
| pin_out | output | WIDTH (32) | Output value for each line |
| pin_oe | output | WIDTH (32) | Output enable for each line, 1 = drive |

## Verification
On every cycle the assertions check four things: the set and clear writes against the previous output register, that nothing changes while the block is not selected, that each synchronizer stage follows its predecessor, and that readback of the output and direction registers matches the pins they drive. The directed scenarios are the only evidence for what the assertions cannot see: the exact two-edge latency seen through the bus, the zero reads from write-only and unmapped indices, and aliased high-address writes being ignored. They also show that a direction change leaves the output values unchanged.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
   // register indices carried in the low three address bits
   localparam int unsigned IDX_W = 3;
   localparam logic [IDX_W-1:0] IDX_PINS = 3'd0;
   localparam logic [IDX_W-1:0] IDX_OUT  = 3'd1;
   localparam logic [IDX_W-1:0] IDX_SET  = 3'd2;
   localparam logic [IDX_W-1:0] IDX_CLR  = 3'd3;
   localparam logic [IDX_W-1:0] IDX_DIR  = 3'd4;
endpackage

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   localparam int unsigned LAST = STAGES - 1;

   initial begin
      if (STAGES < 2) $error("gpio_sc_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("gpio_sc_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[gi] <= '0;
               else        stg[gi] <= stg[gi-1];
            end
         end
      end
   endgenerate

   assign dout = stg[LAST];

   // R7
   first_stage_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (stg[0] == $past(din)));

   // R7
   last_stage_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (dout == $past(stg[LAST-1])));
endmodule

// File: rtl/gpio_sc_regs.sv
module gpio_sc_regs
   import gpio_sc_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] out_q,
   output logic [WIDTH-1:0] dir_q
);
   initial begin
      if (WIDTH < 1) $error("gpio_sc_regs: WIDTH must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
      end else if (wr_en) begin
         case (wr_idx)
            IDX_OUT: out_q <= wr_data;
            IDX_SET: out_q <= out_q | wr_data;
            IDX_CLR: out_q <= out_q & ~wr_data;
            IDX_DIR: dir_q <= wr_data;
            default: ;
         endcase
      end
   end

   // R3
   set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_SET) |=> (out_q == ($past(out_q) | $past(wr_data))));

   // R4
   clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_CLR) |=> (out_q == ($past(out_q) & ~$past(wr_data))));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(out_q) && $stable(dir_q)));
endmodule

// File: rtl/gpio_sc_rdmux.sv
module gpio_sc_rdmux
   import gpio_sc_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [WIDTH-1:0] pins_sync,
   input  logic [WIDTH-1:0] out_q,
   input  logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] rd_data
);
   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (rd_idx)
            IDX_PINS: rd_data = pins_sync;
            IDX_OUT:  rd_data = out_q;
            IDX_DIR:  rd_data = dir_q;
            default:  rd_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
   import gpio_sc_pkg::*;
#(
   parameter int unsigned WIDTH       = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe
);
   initial begin
      if (ADDR_W < IDX_W) $error("gpio_setclr_port: ADDR_W must be at least 3");
      if (WIDTH < 1)      $error("gpio_setclr_port: WIDTH must be at least 1");
   end

   logic             hi_zero;
   logic [IDX_W-1:0] idx;
   logic             wr_en;
   logic             rd_en;
   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] out_q;
   logic [WIDTH-1:0] dir_q;

   assign idx = bus_addr[IDX_W-1:0];

   generate
      if (ADDR_W > IDX_W) begin : g_hi
         assign hi_zero = ~|bus_addr[ADDR_W-1:IDX_W];
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign wr_en = bus_sel & bus_we & hi_zero;
   assign rd_en = bus_sel & ~bus_we & hi_zero;

   gpio_sc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .dout  (pins_sync)
   );

   gpio_sc_regs #(.WIDTH(WIDTH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (idx),
      .wr_data (bus_wdata),
      .out_q   (out_q),
      .dir_q   (dir_q)
   );

   gpio_sc_rdmux #(.WIDTH(WIDTH)) u_rdmux (
      .rd_en     (rd_en),
      .rd_idx    (idx),
      .pins_sync (pins_sync),
      .out_q     (out_q),
      .dir_q     (dir_q),
      .rd_data   (bus_rdata)
   );

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pin_oe == '0 && pin_out == '0));

   // R5
   dir_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && hi_zero && idx == IDX_DIR) |-> (bus_rdata == pin_oe));

   // R6
   out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && hi_zero && idx == IDX_OUT) |-> (bus_rdata == pin_out));

   // R8
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel || bus_we) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_setclr_port_tb.sv
module gpio_setclr_port_tb;
   localparam int W = 32;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   logic [W-1:0]  bus_rdata;
   logic [W-1:0]  pin_in = '0;
   logic [W-1:0]  pin_out;
   logic [W-1:0]  pin_oe;

   int checks = 0;
   int fails = 0;
   logic [W-1:0] exp_out = '0;
   logic [W-1:0] exp_dir = '0;

   always #4 clk = ~clk;

   gpio_setclr_port #(.WIDTH(W), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic t_reset();
      logic [W-1:0] r;
      chk("R1 pin_oe", pin_oe, '0);
      chk("R1 pin_out", pin_out, '0);
      bus_read(5'd4, r); chk("R1 dir read", r, '0);
      bus_read(5'd1, r); chk("R1 out read", r, '0);
   endtask

   task automatic t_direct();
      logic [W-1:0] r;
      bus_write(5'd1, 32'hA5A5_0F0F); exp_out = 32'hA5A5_0F0F;
      chk("R2 pin_out", pin_out, exp_out);
      bus_write(5'd1, 32'h1234_5678); exp_out = 32'h1234_5678;
      chk("R2 replace", pin_out, exp_out);
      bus_read(5'd1, r); chk("R2 readback", r, exp_out);
   endtask

   task automatic t_set();
      logic [W-1:0] r;
      bus_write(5'd2, 32'h8000_0001); exp_out = exp_out | 32'h8000_0001;
      chk("R3 set", pin_out, 32'h9234_5679);
      bus_read(5'd2, r); chk("R8 set reads zero", r, '0);
   endtask

   task automatic t_clear();
      logic [W-1:0] r;
      bus_write(5'd3, 32'h0000_FFFF); exp_out = exp_out & ~32'h0000_FFFF;
      chk("R4 clear", pin_out, 32'h9234_0000);
      bus_write(5'd3, 32'h0); chk("R4 empty mask", pin_out, exp_out);
      bus_read(5'd3, r); chk("R8 clr reads zero", r, '0);
   endtask

   task automatic t_direction();
      logic [W-1:0] r;
      bus_write(5'd4, 32'hFFFF_0000); exp_dir = 32'hFFFF_0000;
      chk("R5 pin_oe", pin_oe, exp_dir);
      bus_read(5'd4, r); chk("R5 readback", r, exp_dir);
      chk("R6 out with partial dir", pin_out, exp_out);
      bus_write(5'd4, 32'h0); exp_dir = '0;
      chk("R6 out after dir clear", pin_out, exp_out);
      chk("R5 oe cleared", pin_oe, '0);
   endtask

   task automatic t_sync();
      logic [W-1:0] r;
      pin_in = 32'h0F0F_1111;
      repeat (3) @(negedge clk);
      bus_read(5'd0, r); chk("R7 settled", r, 32'h0F0F_1111);
      @(negedge clk);
      pin_in = 32'hDEAD_BEEF;
      #1; r = bus_rdata;
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'd0; #1; r = bus_rdata;
      chk("R7 before edge", r, 32'h0F0F_1111);
      @(negedge clk); #1; r = bus_rdata;
      chk("R7 after one edge", r, 32'h0F0F_1111);
      @(negedge clk); #1; r = bus_rdata;
      chk("R7 after two edges", r, 32'hDEAD_BEEF);
      bus_sel = 1'b0;
   endtask

   task automatic t_readmap();
      logic [W-1:0] r;
      for (int a = 5; a < 8; a++) begin
         bus_read(AW'(a), r); chk("R8 unmapped read", r, '0);
      end
      bus_read(5'd9, r); chk("R8 high-alias read", r, '0);
      @(negedge clk); bus_addr = 5'd1; #1;
      chk("R8 unselected read", bus_rdata, '0);
   endtask

   task automatic t_ignored();
      logic [W-1:0] r;
      bus_write(5'd0, 32'hFFFF_FFFF);
      bus_write(5'd5, 32'hFFFF_FFFF);
      bus_write(5'd9, 32'h0000_0000);
      bus_write(5'd12, 32'hFFFF_FFFF);
      chk("R9 out kept", pin_out, exp_out);
      chk("R9 dir kept", pin_oe, exp_dir);
      bus_read(5'd1, r); chk("R9 out readback", r, exp_out);
   endtask

   task automatic t_nosel();
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b1; bus_addr = 5'd1; bus_wdata = 32'h5555_AAAA;
      @(negedge clk);
      bus_addr = 5'd4;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
      chk("R10 out kept", pin_out, exp_out);
      chk("R10 dir kept", pin_oe, exp_dir);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_set();
      t_clear();
      t_direction();
      t_sync();
      t_readmap();
      t_ignored();
      t_nosel();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule